// File: doc/BRIEF.md
# SD Command Frame Transmitter

This block drives the single bidirectional command wire of an SD card interface. When idle it accepts a request: a command index, a 32-bit argument and a flag that selects a short (48-bit) or long (136-bit) reply. It then shifts out a complete 48-bit token, MSB first. The token holds a start bit, a host-direction bit, the index, the argument, a CRC7 that is computed while the bits go out, and a stop bit.

After the token it releases the wire and watches for the card's start bit. It captures the reply and checks the reply's CRC7 where the reply carries one. It ends with a one-cycle done pulse, together with a timeout flag or a CRC error flag.

The card clock is produced elsewhere. The block runs on the system clock and gets two single-cycle strobes from the clock generator. The drive strobe marks each falling edge of the card clock, and the sample strobe marks each rising edge. The block changes the wire only on drive strobes and reads it only on sample strobes.

Top module: `sdcmd_engine`

## Requirements
- R1: During and right after synchronous reset, cmd_oe=0, cmd_out=1, busy=0, done=0, timeout=0, crc_err=0 and rsp_data is all zeros.
- R2: An accepted command puts 48 bits on cmd_out, one per drive strobe, with cmd_oe=1. In order these are: 0, 1, the 6-bit index MSB first, the 32-bit argument MSB first, seven CRC bits, and a final 1.
- R3: The seven CRC bits of the token are the CRC7 (generator x^7+x^3+1, register cleared to zero) of the first 40 token bits, sent MSB first. For example, index 0 with argument 0 gives token 0x400000000095.
- R4: cmd_out and cmd_oe change only in the cycle after a drive strobe. At the drive strobe that follows the stop bit, cmd_oe goes to 0.
- R5: After release, each sample strobe that reads 1 counts toward a limit of 64. If the 64th sample is still 1, timeout=1 and done pulses. A 0 read on the 64th sample is taken as a valid start bit.
- R6: When the short length is selected, the first 0 sample and the 47 samples after it are captured MSB first into rsp_data[47:0], and rsp_data[135:48] reads zero.
- R7: When the long length is selected, 136 samples starting with the start bit are captured MSB first into rsp_data[135:0].
- R8: For a short reply, crc_err=1 when response bits [7:1] differ from the CRC7 of response bits [47:8].
- R9: For a long reply, crc_err=1 when response bits [7:1] differ from the CRC7 of response bits [127:8].
- R10: A reply whose bits [7:1] are all ones never raises crc_err.
- R11: A start request while busy=1 is ignored: the token already on the wire and the reply capture in progress are not affected.
- R12: done is high for exactly one cycle per command, in the same cycle that busy falls. timeout and crc_err are valid with done and keep their values until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_stb | input | 1 | One-cycle strobe marking a card-clock falling edge |
| smp_stb | input | 1 | One-cycle strobe marking a card-clock rising edge |
| start | input | 1 | Request a new command (taken only when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_long | input | 1 | 1 selects a 136-bit reply, 0 a 48-bit reply |
| cmd_in | input | 1 | Command wire as seen at the pad |
| cmd_out | output | 1 | Value driven onto the command wire |
| cmd_oe | output | 1 | Output enable for the command wire |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | No start bit arrived within the wait limit |
| crc_err | output | 1 | Reply CRC7 mismatch |
| rsp_data | output | 136 | Captured reply, right-aligned |

## Verification
The bench sweeps all 64 command indices and compares every token bit with a CRC7 worked out by polynomial long division. A design with a wrong tap, a wrong seed or a wrong coverage range sends a bad CRC field. The wait limit is probed on both sides of its edge: a start bit on the 64th sample, and silence through the 64th sample. An off-by-one counter would time out a valid reply or wait one sample too long.

Short and long replies are mixed with good, corrupted and all-ones CRC fields. A design that checks the wrong window of the long reply, or ignores the all-ones rule, flags good replies or misses bad ones. A short reply that follows a long one catches a capture register that is not cleared between commands. Start requests injected during transmit and during capture catch a design that restarts mid-command.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } sdcmd_state_e;

  // One serial step of the CRC7 shift register.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/sdcmd_serializer.sv
module sdcmd_serializer
  import sdcmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [ARG_W-1:0] arg_i,
  input  logic             adv_i,
  output logic             bit_o,
  output logic             sent_all_o
);
  localparam int BODY_W  = 2 + IDX_W + ARG_W;
  localparam int TOKEN_W = BODY_W + CRC_W + 1;
  localparam int CNT_W   = $clog2(TOKEN_W + 1);
  localparam logic [CNT_W-1:0] BODY_END = CNT_W'(BODY_W);
  localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(BODY_W + CRC_W);
  localparam logic [CNT_W-1:0] TOK_END  = CNT_W'(TOKEN_W);

  logic [BODY_W-1:0] body_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    if (cnt_q < BODY_END)     bit_o = body_q[BODY_W-1];
    else if (cnt_q < CRC_END) bit_o = crc_q[CRC_W-1];
    else                      bit_o = 1'b1;
  end

  assign sent_all_o = (cnt_q == TOK_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      body_q <= '0;
      crc_q  <= '0;
      cnt_q  <= TOK_END;
    end else if (load_i) begin
      body_q <= {1'b0, 1'b1, idx_i, arg_i};
      crc_q  <= '0;
      cnt_q  <= '0;
    end else if (adv_i && !sent_all_o) begin
      if (cnt_q < BODY_END) begin
        crc_q  <= crc_step(crc_q, body_q[BODY_W-1]);
        body_q <= {body_q[BODY_W-2:0], 1'b0};
      end else if (cnt_q < CRC_END) begin
        crc_q <= {crc_q[CRC_W-2:0], 1'b0};
      end
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdcmd_deserializer.sv
module sdcmd_deserializer
  import sdcmd_pkg::*;
#(
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int LONG_SKIP = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear_i,
  input  logic                long_i,
  input  logic                shift_i,
  input  logic                bit_i,
  output logic [LONG_LEN-1:0] data_o,
  output logic                full_o,
  output logic                crc_bad_o
);
  localparam int TAIL_W = CRC_W + 1;
  localparam int CNT_W  = $clog2(LONG_LEN + 1);
  localparam logic [CNT_W-1:0] S_LEN  = CNT_W'(SHORT_LEN);
  localparam logic [CNT_W-1:0] L_LEN  = CNT_W'(LONG_LEN);
  localparam logic [CNT_W-1:0] S_CEND = CNT_W'(SHORT_LEN - TAIL_W);
  localparam logic [CNT_W-1:0] L_CBEG = CNT_W'(LONG_SKIP);
  localparam logic [CNT_W-1:0] L_CEND = CNT_W'(LONG_LEN - TAIL_W);

  logic [LONG_LEN-1:0] sh_q;
  logic [CRC_W-1:0]    crc_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                covered;
  logic [CRC_W-1:0]    field;

  assign covered = long_i ? (cnt_q >= L_CBEG && cnt_q < L_CEND) : (cnt_q < S_CEND);
  assign full_o  = (cnt_q == (long_i ? L_LEN : S_LEN));
  assign field   = sh_q[CRC_W:1];
  assign crc_bad_o = (field != '1) && (field != crc_q);
  assign data_o  = sh_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      sh_q  <= '0;
      crc_q <= '0;
      cnt_q <= '0;
    end else if (shift_i && !full_o) begin
      sh_q <= {sh_q[LONG_LEN-2:0], bit_i};
      if (covered) crc_q <= crc_step(crc_q, bit_i);
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int LONG_SKIP = 8,
  parameter int RSP_TMO   = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                drv_stb,
  input  logic                smp_stb,
  input  logic                start,
  input  logic [IDX_W-1:0]    cmd_idx,
  input  logic [ARG_W-1:0]    cmd_arg,
  input  logic                rsp_long,
  input  logic                cmd_in,
  output logic                cmd_out,
  output logic                cmd_oe,
  output logic                busy,
  output logic                done,
  output logic                timeout,
  output logic                crc_err,
  output logic [LONG_LEN-1:0] rsp_data
);
  localparam int TMO_W = $clog2(RSP_TMO + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(RSP_TMO - 1);

  sdcmd_state_e     state_q;
  logic [TMO_W-1:0] tmo_q;
  logic             long_q;
  logic             ser_load, ser_adv, ser_bit, ser_all;
  logic             rx_shift, rx_full, rx_bad;

  assign ser_load = (state_q == ST_IDLE) && start;
  assign ser_adv  = (state_q == ST_SEND) && drv_stb && !ser_all;
  assign rx_shift = smp_stb &&
                    (((state_q == ST_WAIT) && !cmd_in) ||
                     ((state_q == ST_RECV) && !rx_full));

  sdcmd_serializer #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .load_i    (ser_load),
    .idx_i     (cmd_idx),
    .arg_i     (cmd_arg),
    .adv_i     (ser_adv),
    .bit_o     (ser_bit),
    .sent_all_o(ser_all)
  );

  sdcmd_deserializer #(
    .SHORT_LEN(SHORT_LEN),
    .LONG_LEN (LONG_LEN),
    .LONG_SKIP(LONG_SKIP)
  ) u_des (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (ser_load),
    .long_i   (long_q),
    .shift_i  (rx_shift),
    .bit_i    (cmd_in),
    .data_o   (rsp_data),
    .full_o   (rx_full),
    .crc_bad_o(rx_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tmo_q   <= '0;
      long_q  <= 1'b0;
      cmd_out <= 1'b1;
      cmd_oe  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
      crc_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_SEND;
          busy    <= 1'b1;
          long_q  <= rsp_long;
          timeout <= 1'b0;
          crc_err <= 1'b0;
        end
        ST_SEND: if (drv_stb) begin
          if (ser_all) begin
            cmd_oe  <= 1'b0;
            cmd_out <= 1'b1;
            tmo_q   <= '0;
            state_q <= ST_WAIT;
          end else begin
            cmd_oe  <= 1'b1;
            cmd_out <= ser_bit;
          end
        end
        ST_WAIT: if (smp_stb) begin
          if (!cmd_in) begin
            state_q <= ST_RECV;
          end else if (tmo_q == TMO_LAST) begin
            timeout <= 1'b1;
            done    <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        ST_RECV: if (rx_full) begin
          crc_err <= rx_bad;
          done    <= 1'b1;
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
  input logic clk,
  input logic rst,
  input logic drv_stb,
  input logic start,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic crc_err,
  input logic cmd_out,
  input logic cmd_oe
);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_fall_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_flag_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(timeout) && $stable(crc_err)));

  assert_line_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !drv_stb |=> ($stable(cmd_out) && $stable(cmd_oe)));

  assert_idle_released_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_oe);

  assert_timeout_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> (done && !crc_err));

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && start) |=> (busy || done));
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .drv_stb(drv_stb),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .timeout(timeout),
  .crc_err(crc_err),
  .cmd_out(cmd_out),
  .cmd_oe (cmd_oe)
);

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, drv_stb, smp_stb, start, rsp_long, cmd_in;
  logic [5:0]   cmd_idx;
  logic [31:0]  cmd_arg;
  logic         cmd_out, cmd_oe, busy, done, timeout, crc_err;
  logic [135:0] rsp_data;

  int n_tests = 0;
  int n_fail  = 0;

  sdcmd_engine u_dut (
    .clk(clk), .rst(rst), .drv_stb(drv_stb), .smp_stb(smp_stb),
    .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_long(rsp_long),
    .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy),
    .done(done), .timeout(timeout), .crc_err(crc_err), .rsp_data(rsp_data)
  );

  task automatic check_eq(input string tag, input logic [135:0] act,
                          input logic [135:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // CRC7 by long division of msg * x^7 by x^7+x^3+1; msg is right aligned, n bits.
  function automatic logic [6:0] crc_ref(input logic [127:0] msg, input int n);
    logic [134:0] v;
    v = {7'b0, msg} << 7;
    for (int i = n + 6; i >= 7; i--)
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
    return v[6:0];
  endfunction

  // One card-clock period: falling edge strobe, read, rising edge strobe.
  task automatic card_cycle(input logic din, input logic inj,
                            output logic o, output logic oe);
    @(negedge clk); drv_stb = 1'b1; cmd_in = din;
    @(negedge clk); drv_stb = 1'b0; o = cmd_out; oe = cmd_oe;
    if (inj) begin
      start = 1'b1; cmd_idx = ~cmd_idx; cmd_arg = ~cmd_arg; rsp_long = ~rsp_long;
    end
    @(negedge clk); start = 1'b0; smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
  endtask

  // kind: 0 good CRC, 1 corrupted CRC, 2 all-ones CRC field, 3 no reply
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                         input logic lng, input int delay, input int kind,
                         input int inj_at, output logic [47:0] tok);
    logic [47:0]  exp_tok;
    logic [135:0] rsp;
    logic [39:0]  b40;
    logic [119:0] pay;
    logic [6:0]   c, bad;
    logic         o, oe, oe_ok;
    int           rlen, k;
    string        rtag, ctag;
    exp_tok = {2'b01, idx, arg, crc_ref({88'b0, 2'b01, idx, arg}, 40), 1'b1};
    if (!lng) begin
      b40 = {2'b00, idx, arg ^ 32'hA5A5_0F0F};
      c   = crc_ref({88'b0, b40}, 40);
    end else begin
      pay = {arg, ~arg, arg + 32'h1357_9BDF, idx, 2'b11, idx, 2'b01, idx, 2'b10};
      c   = crc_ref({8'b0, pay}, 120);
    end
    bad = c ^ 7'h01;
    if (bad == 7'h7F) bad = c ^ 7'h02;
    if (kind == 1) c = bad;
    if (kind == 2) c = 7'h7F;
    rsp  = lng ? {8'h3F, pay, c, 1'b1} : {88'b0, b40, c, 1'b1};
    rlen = lng ? 136 : 48;
    rtag = lng ? "R7" : "R6";
    ctag = (kind == 2) ? "R10" : (lng ? "R9" : "R8");

    @(negedge clk);
    start = 1'b1; cmd_idx = idx; cmd_arg = arg; rsp_long = lng;
    @(negedge clk);
    start = 1'b0;
    check_eq("R12 busy after accept", {135'b0, busy}, 136'd1);

    oe_ok = 1'b1;
    tok   = '0;
    k     = 0;
    for (int j = 0; j < 49; j++) begin
      card_cycle(1'b1, k == inj_at, o, oe);
      if (j < 48) begin
        tok[47-j] = o;
        if (!oe) oe_ok = 1'b0;
      end else if (oe) oe_ok = 1'b0;
      k++;
    end
    check_eq("R2 token framing", {96'b0, tok[47:8]}, {96'b0, exp_tok[47:8]});
    check_eq("R3 token crc", {128'b0, tok[7:0]}, {128'b0, exp_tok[7:0]});
    check_eq("R4 drive then release", {135'b0, oe_ok}, 136'd1);

    for (int j = 0; j < delay; j++) begin
      card_cycle(1'b1, k == inj_at, o, oe);
      k++;
    end

    if (kind == 3) begin
      check_eq("R5 timeout flag", {133'b0, done, timeout, crc_err}, {133'b0, 3'b110});
      check_eq("R12 busy drops with done", {135'b0, busy}, 136'd0);
      @(negedge clk);
      check_eq("R12 done one cycle", {135'b0, done}, 136'd0);
      repeat (3) @(negedge clk);
      check_eq("R12 timeout held", {135'b0, timeout}, 136'd1);
    end else begin
      for (int j = 0; j < rlen; j++) begin
        card_cycle(rsp[rlen-1-j], k == inj_at, o, oe);
        k++;
      end
      @(negedge clk);
      check_eq("R12 done pulse", {134'b0, done, busy}, {134'b0, 2'b10});
      check_eq({"R5 no timeout (", rtag, ")"}, {135'b0, timeout}, 136'd0);
      check_eq({ctag, " crc flag"}, {135'b0, crc_err}, {135'b0, kind == 1});
      check_eq({rtag, " captured reply"}, rsp_data, rsp);
      @(negedge clk);
      check_eq("R12 done one cycle", {135'b0, done}, 136'd0);
      repeat (2) @(negedge clk);
      check_eq("R12 crc flag held", {135'b0, crc_err}, {135'b0, kind == 1});
    end
    if (inj_at >= 0) begin
      check_eq("R11 start while busy ignored (token)", {88'b0, tok}, {88'b0, exp_tok});
      if (kind != 3) check_eq("R11 start while busy ignored (reply)", rsp_data, rsp);
    end
    cmd_in = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] tok;
    rst = 1'b1; drv_stb = 1'b0; smp_stb = 1'b0; start = 1'b0;
    cmd_idx = '0; cmd_arg = '0; rsp_long = 1'b0; cmd_in = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1 outputs in reset",
             {130'b0, cmd_oe, cmd_out, busy, done, timeout, crc_err},
             {130'b0, 6'b010000});
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 outputs after reset",
             {130'b0, cmd_oe, cmd_out, busy, done, timeout, crc_err},
             {130'b0, 6'b010000});
    check_eq("R1 reply register cleared", rsp_data, 136'b0);

    run_cmd(6'd0, 32'h0, 1'b0, 2, 0, -1, tok);
    check_eq("R3 known token idx0", {88'b0, tok}, {88'b0, 48'h40_0000_0000_95});
    run_cmd(6'd8, 32'h0000_01AA, 1'b0, 3, 0, -1, tok);
    check_eq("R3 known token idx8", {88'b0, tok}, {88'b0, 48'h48_0000_01AA_87});

    // Sweep every index with mixed reply lengths, CRC kinds, delays
    for (int i = 0; i < 64; i++) begin
      int kind, inj;
      kind = (i % 7 == 3) ? 1 : ((i % 7 == 5) ? 2 : 0);
      inj  = (i == 9) ? 12 : ((i == 21) ? 70 : -1);
      run_cmd(6'(i), 32'h9E37_79B9 * (i + 1), (i % 4) == 2, i % 9, kind, inj, tok);
    end

    // Wait-limit edges
    run_cmd(6'd17, 32'hDEAD_BEEF, 1'b0, 63, 3, -1, tok);
    run_cmd(6'd18, 32'h0123_4567, 1'b0, 62, 0, -1, tok);
    run_cmd(6'd2, 32'h0, 1'b1, 62, 0, -1, tok);
    run_cmd(6'd9, 32'hFFFF_0000, 1'b1, 63, 3, 55, tok);
    // Long then short: upper capture bits must clear
    run_cmd(6'd10, 32'h5555_AAAA, 1'b1, 1, 1, -1, tok);
    run_cmd(6'd13, 32'h1, 1'b0, 0, 0, -1, tok);
    run_cmd(6'd3, 32'h7, 1'b1, 4, 2, 100, tok);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule